// File: doc/BRIEF.md
# DSP Condition Flag Selector

This block takes the result of a DSP-style ALU operation and works out its status flags. The result is held in a 40-bit accumulator: a 32-bit body whose bit 31 is the sign, with 8 guard bits above it. A 3-bit mode code picks one condition from those flags and drives it onto a single registered condition bit, DC. Conditional-execution logic further down the pipe can then test that one bit without knowing which condition it stands for.

Overflow is always judged against the 32-bit body. A value that needs the guard bits counts as an overflow, even though the accumulator can hold it. The signed-greater-than and greater-or-equal conditions use that overflow to correct the sign of a compare result whose subtraction went out of range. An operation-class tag tells the block whether the result came from arithmetic, logical or compare work. For logical work, overflow and carry are suppressed and the zero test looks only at the body. DC and the four flags change only on a clock edge where the update strobe is high.

Top module: `dcsel_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `dc_o`, `z_o`, `n_o`, `v_o` and `gt_o` to 0 on that edge.
- R2: At a rising edge where `upd_i` is low and reset is inactive, all five outputs keep their previous values, whatever the other inputs are.
- R3: Z is 1 when the whole 40-bit result is zero. For the logical class (`op_i` = 01) it looks only at bits 31..0. Mode code 010 makes DC equal to Z.
- R4: For the arithmetic (00), compare (10) and unassigned (11) classes, V is 1 when bits 39..31 of the result are not all equal. A value that reaches only into the guard bits is therefore an overflow. Mode code 011 makes DC equal to V.
- R5: N is bit 31 of the result. Mode code 001 makes DC equal to bit 39 for the non-logical classes and to bit 31 for the logical class.
- R6: GT is 1 when Z is 0 and N equals V, so the sign is read inverted whenever V is 1. Mode code 100 makes DC equal to GT.
- R7: Mode code 101 makes DC equal to NOT(N XOR V), the signed greater-or-equal condition.
- R8: Mode code 000 makes DC equal to `carry_i` for the non-logical classes.
- R9: For the logical class, V is 0 and the carry seen by mode 000 is 0, whatever the guard bits and `carry_i` hold.
- R10: Mode codes 110 and 111 give DC = 0 on an update.
- R11: Every update loads the flags and DC computed from the inputs present at that same rising edge. The registered outputs show the new values one edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe; when high the outputs load new values |
| mode_i | input | 3 | Condition code choosing what DC reflects |
| op_i | input | 2 | Operation class: 00 arithmetic, 01 logical, 10 compare, 11 treated as arithmetic |
| result_i | input | 40 | ALU result, 8 guard bits above a 32-bit body |
| carry_i | input | 1 | Adder carry/borrow out |
| dc_o | output | 1 | Registered selected condition bit |
| z_o | output | 1 | Registered zero flag |
| n_o | output | 1 | Registered negative flag (bit 31) |
| v_o | output | 1 | Registered overflow flag |
| gt_o | output | 1 | Registered signed-greater-than flag |

## Verification
The assertions assume that `mode_i`, `op_i`, `result_i` and `carry_i` are known and steady around each rising edge where `upd_i` is high. They check the outputs one edge later against the mode code that was present at the update. The bench changes inputs only on falling edges, so every update edge sees settled values. The sweep visits every mode code and class at the signed body limits, just beyond them and in the guard bits alone. It then adds hold periods with the strobe low and a mid-run reset.

// File: rtl/dcsel_pkg.sv
package dcsel_pkg;

    localparam int GUARD_W = 8;
    localparam int BODY_W  = 32;
    localparam int ACC_W   = GUARD_W + BODY_W;
    localparam int MODE_W  = 3;
    localparam int OPC_W   = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_ARITH = 2'b00,
        OP_LOGIC = 2'b01,
        OP_CMP   = 2'b10,
        OP_SPARE = 2'b11
    } op_cls_e;

    typedef enum logic [MODE_W-1:0] {
        SEL_CARRY = 3'd0,
        SEL_NEG   = 3'd1,
        SEL_ZERO  = 3'd2,
        SEL_OVF   = 3'd3,
        SEL_SGT   = 3'd4,
        SEL_SGE   = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } dc_sel_e;

    // Combinational flag bundle between the flag stage and the selector.
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic gt;
        logic neg_top;
    } flag_bus_t;

    // Registered state of the block.
    typedef struct packed {
        logic dc;
        logic z;
        logic n;
        logic v;
        logic gt;
    } cond_state_t;

endpackage

// File: rtl/dcsel_flag_calc.sv
module dcsel_flag_calc
    import dcsel_pkg::*;
#(
    parameter int G_W = GUARD_W,
    parameter int B_W = BODY_W
) (
    input  logic [G_W+B_W-1:0] result_i,
    input  logic               carry_i,
    input  logic [OPC_W-1:0]   op_i,
    output flag_bus_t          flags_o
);
    localparam int A_W      = G_W + B_W;
    localparam int SIGN_POS = B_W - 1;
    localparam int SPAN_W   = A_W - SIGN_POS;

    logic [SPAN_W-1:0] span;
    logic              span_ones;
    logic              span_zeros;
    logic              is_logic;
    logic              body_zero;
    logic              full_zero;

    // Guard bits plus body sign must agree for the value to fit the body.
    assign span       = result_i[A_W-1:SIGN_POS];
    assign span_ones  = &span;
    assign span_zeros = ~|span;
    assign is_logic   = (op_i == OP_LOGIC);
    assign body_zero  = ~|result_i[B_W-1:0];
    assign full_zero  = body_zero & ~|result_i[A_W-1:B_W];

    always_comb begin
        flags_o         = '0;
        flags_o.n       = result_i[SIGN_POS];
        flags_o.z       = is_logic ? body_zero : full_zero;
        flags_o.v       = is_logic ? 1'b0 : ~(span_ones | span_zeros);
        flags_o.c       = is_logic ? 1'b0 : carry_i;
        flags_o.neg_top = is_logic ? result_i[SIGN_POS] : result_i[A_W-1];
        flags_o.gt      = ~(flags_o.n ^ flags_o.v) & ~flags_o.z;
    end

endmodule

// File: rtl/dcsel_mode_mux.sv
module dcsel_mode_mux
    import dcsel_pkg::*;
(
    input  flag_bus_t         flags_i,
    input  logic [MODE_W-1:0] sel_i,
    output logic              dc_o
);
    always_comb begin
        unique case (dc_sel_e'(sel_i))
            SEL_CARRY: dc_o = flags_i.c;
            SEL_NEG:   dc_o = flags_i.neg_top;
            SEL_ZERO:  dc_o = flags_i.z;
            SEL_OVF:   dc_o = flags_i.v;
            SEL_SGT:   dc_o = flags_i.gt;
            SEL_SGE:   dc_o = ~(flags_i.n ^ flags_i.v);
            default:   dc_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcsel_top.sv
module dcsel_top
    import dcsel_pkg::*;
#(
    parameter int G_W = GUARD_W,
    parameter int B_W = BODY_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [OPC_W-1:0]     op_i,
    input  logic [G_W+B_W-1:0]   result_i,
    input  logic                 carry_i,
    output logic                 dc_o,
    output logic                 z_o,
    output logic                 n_o,
    output logic                 v_o,
    output logic                 gt_o
);
    flag_bus_t   flags_w;
    logic        dc_w;
    cond_state_t st_d;
    cond_state_t st_q;

    dcsel_flag_calc #(.G_W(G_W), .B_W(B_W)) u_flags (
        .result_i (result_i),
        .carry_i  (carry_i),
        .op_i     (op_i),
        .flags_o  (flags_w)
    );

    dcsel_mode_mux u_sel (
        .flags_i (flags_w),
        .sel_i   (mode_i),
        .dc_o    (dc_w)
    );

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            st_d.dc = dc_w;
            st_d.z  = flags_w.z;
            st_d.n  = flags_w.n;
            st_d.v  = flags_w.v;
            st_d.gt = flags_w.gt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dc_o = st_q.dc;
    assign z_o  = st_q.z;
    assign n_o  = st_q.n;
    assign v_o  = st_q.v;
    assign gt_o = st_q.gt;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !(dc_o | z_o | n_o | v_o | gt_o)); // R1
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst) !upd_i |=> ($stable(dc_o) && $stable(z_o) && $stable(n_o) && $stable(v_o) && $stable(gt_o))); // R2
    AST_ZERO_MODE: assert property (@(posedge clk) disable iff (rst) (upd_i && mode_i == SEL_ZERO) |=> dc_o == z_o); // R3
    AST_OVF_MODE: assert property (@(posedge clk) disable iff (rst) (upd_i && mode_i == SEL_OVF) |=> dc_o == v_o); // R4
    AST_GT_NOT_ZERO: assert property (@(posedge clk) disable iff (rst) z_o |-> !gt_o); // R6
    AST_SGT_MODE: assert property (@(posedge clk) disable iff (rst) (upd_i && mode_i == SEL_SGT) |=> dc_o == gt_o); // R6
    AST_SGE_MODE: assert property (@(posedge clk) disable iff (rst) (upd_i && mode_i == SEL_SGE) |=> dc_o == !(n_o ^ v_o)); // R7
    AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst) (upd_i && op_i == OP_LOGIC) |=> !v_o); // R9
    AST_RSV_MODE: assert property (@(posedge clk) disable iff (rst) (upd_i && mode_i[2:1] == 2'b11) |=> !dc_o); // R10

endmodule

// File: tb/tb_dcsel_top.sv
module tb_dcsel_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  op_i = '0;
    logic [39:0] result_i = '0;
    logic        carry_i = 1'b0;
    logic        dc_o, z_o, n_o, v_o, gt_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit armed   = 1'b0;

    always #4 clk = ~clk;

    dcsel_top dut (
        .clk(clk), .rst(rst), .upd_i(upd_i), .mode_i(mode_i), .op_i(op_i),
        .result_i(result_i), .carry_i(carry_i),
        .dc_o(dc_o), .z_o(z_o), .n_o(n_o), .v_o(v_o), .gt_o(gt_o)
    );

    // Behavioural reference state
    logic  e_dc, e_z, e_n, e_v, e_gt;
    string t_dc, t_z, t_n, t_v, t_gt;

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        longint sv;
        bit     lg, ovf, zr, ng;
        if (rst) begin
            {e_dc, e_z, e_n, e_v, e_gt} = '0;
            t_dc = "R1"; t_z = "R1"; t_n = "R1"; t_v = "R1"; t_gt = "R1";
            armed = 1'b1;
        end else if (!upd_i) begin
            t_dc = "R2"; t_z = "R2"; t_n = "R2"; t_v = "R2"; t_gt = "R2";
        end else begin
            lg  = (op_i == 2'b01);
            sv  = longint'($signed(result_i));
            ovf = lg ? 1'b0 : ((sv > 64'sd2147483647) || (sv < -64'sd2147483648));
            zr  = lg ? (result_i[31:0] == 32'd0) : (sv == 0);
            ng  = result_i[31];
            e_z = zr; e_n = ng; e_v = ovf;
            // corrected sign: a compare that overflowed shows the wrong sign
            e_gt = !zr && ((ng != ovf) == 1'b0);
            t_z = "R3"; t_n = "R5"; t_v = lg ? "R9" : "R4"; t_gt = "R6";
            case (mode_i)
                3'd0: begin e_dc = lg ? 1'b0 : carry_i; t_dc = lg ? "R9" : "R8"; end
                3'd1: begin e_dc = lg ? result_i[31] : result_i[39]; t_dc = "R5"; end
                3'd2: begin e_dc = zr; t_dc = "R3"; end
                3'd3: begin e_dc = ovf; t_dc = "R4"; end
                3'd4: begin e_dc = e_gt; t_dc = "R6"; end
                3'd5: begin e_dc = (ng == ovf); t_dc = "R7"; end
                default: begin e_dc = 1'b0; t_dc = "R10"; end
            endcase
        end
        #2;
        if (armed) begin
            chk(t_dc, dc_o, e_dc, "dc_o");
            chk(t_z,  z_o,  e_z,  "z_o");
            chk(t_n,  n_o,  e_n,  "n_o");
            chk(t_v,  v_o,  e_v,  "v_o");
            chk(t_gt, gt_o, e_gt, "gt_o");
        end
    end

    task automatic drive(input bit u, input logic [2:0] m, input logic [1:0] o,
                         input logic [39:0] r, input logic c);
        @(negedge clk);
        upd_i = u; mode_i = m; op_i = o; result_i = r; carry_i = c;
    endtask

    logic [39:0] corner [12];
    initial begin
        corner[0]  = 40'h00_0000_0000;
        corner[1]  = 40'h00_0000_0001;
        corner[2]  = 40'h00_7FFF_FFFF;   // +2^31-1
        corner[3]  = 40'h00_8000_0000;   // +2^31, just beyond
        corner[4]  = 40'hFF_8000_0000;   // -2^31
        corner[5]  = 40'hFF_7FFF_FFFF;   // -2^31-1, just beyond
        corner[6]  = 40'h01_0000_0000;   // guard bits only
        corner[7]  = 40'hFF_0000_0000;   // guard bits only, negative pattern
        corner[8]  = 40'h80_0000_0000;   // top guard bit only
        corner[9]  = 40'hFF_FFFF_FFFF;   // -1
        corner[10] = 40'h7F_FFFF_FFFF;
        corner[11] = 40'h00_FFFF_FFFF;
    end

    initial begin
        logic [63:0] lf;
        lf = 64'h9E37_79B9_7F4A_7C15;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: full sweep of every mode, class and corner value
        for (int m = 0; m < 8; m++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 12; k++)
                    for (int c = 0; c < 2; c++)
                        drive(1'b1, m[2:0], o[1:0], corner[k], c[0]);
        // R2: strobe low, inputs churning
        for (int k = 0; k < 40; k++)
            drive(1'b0, k[2:0], k[1:0], corner[k % 12] ^ {k[7:0], 32'h0}, k[0]);
        // R1: reset while an update is requested
        drive(1'b1, 3'd2, 2'b00, 40'h0, 1'b1);
        rst = 1'b1;
        drive(1'b1, 3'd0, 2'b00, 40'h00_0000_0005, 1'b1);
        rst = 1'b0;
        // mixed pseudo-random traffic with occasional holds
        for (int k = 0; k < 600; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            drive(lf[63:60] != 4'h0, lf[2:0], lf[4:3],
                  lf[5] ? {{8{lf[45]}}, lf[45:14]} : lf[47:8], lf[6]);
        end
        drive(1'b0, 3'd0, 2'b00, 40'h0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule